// File: doc/BRIEF.md
# Indirect-Select Vectored Interrupt Controller

This block is a memory-mapped interrupt controller for up to 128 interrupt sources. It is driven over a simple 32-bit register bus. Software first writes a source index into a select register. The per-source registers then act on that one source only: its mode, its vector, enable and disable commands, and set-pending and clear-pending commands. A single registered output raises the processor interrupt.

The interrupt handler reads the vector register. This returns the vector of the highest-priority enabled pending source, and the read also acknowledges that source and pushes its priority onto an 8-deep nesting stack. A source raises the interrupt output only while its priority is strictly above the priority on top of that stack. An end-of-interrupt write pops one stack level. When no source qualifies, the vector read returns a programmable spurious value and changes no state.

Each source is either level type or latched type. A level-type source is pending while its input is high. A latched-type source remembers a one-cycle high input until it is acknowledged or cleared. The source inputs are assumed to be synchronous to the clock already, and a latched-type source is assumed to receive single-cycle pulses.

Top module: `selvic`

## Requirements
- R1: After reset, every source is disabled and not pending, with priority 0 and vector 0. The spurious value is 0, the status register at 0x18 reads 0 and irq_o is low.
- R2: A write to 0x00 selects a source, taking the index from bits [6:0]; the register reads back the index. The mode register at 0x04 holds the priority in bits [2:0] and the type in bits [6:5], where bit 5 = 1 means latched type. The mode register and the vector register at 0x08 read and write only the selected source.
- R3: A write to 0x40 with bit 0 = 1 enables the selected source, and a write to 0x44 with bit 0 = 1 disables it. A write to either with bit 0 = 0 has no effect. Bit 0 of 0x30 shows whether the selected source is enabled. A disabled source never drives irq_o.
- R4: A write of bit 0 = 1 to 0x4C makes the selected source pending, and a write of bit 0 = 1 to 0x48 clears it. Pending state is read at 0x20, 0x24, 0x28 and 0x2C: source i appears at bit i mod 32 of word i/32.
- R5: Among the enabled pending sources, the winner is the one with the highest priority; equal priorities go to the lowest index. A read of 0x10 returns the winner's vector.
- R6: A read of 0x10 that returns a vector pushes the winner's priority and index onto the nesting stack and clears the winner's remembered pending state. The status register 0x18 then reads that source's index.
- R7: A winner interrupts only if the stack is empty or its priority is strictly greater than the priority on top of the stack; otherwise irq_o stays low.
- R8: Each write to 0x38 pops one stack level, and the status register shows the source now on top, or 0 when the stack is empty. Eight consecutive writes empty any stack state, and a write when the stack is already empty changes nothing.
- R9: The spurious value is written and read at 0x3C. A read of 0x10 with no interrupting winner returns the spurious value and leaves the stack unchanged.
- R10: irq_o is a register. A command write accepted at one clock edge is reflected on irq_o at the following edge.
- R11: Bit 0 of the core status register at 0x34 equals irq_o.
- R12: A level-type source is pending whenever its input is high. Acknowledging it does not clear it while the input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NSRC | Interrupt source inputs, synchronous to clk |
| bus_wr | input | 1 | Register write strobe for one cycle |
| bus_rd | input | 1 | Register read strobe for one cycle; read side effects take place at the edge that ends the cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally while bus_rd is high |
| irq_o | output | 1 | Registered processor interrupt request |

## Verification
Read data is combinational, so the bench samples bus_rdata at the falling edge inside the read cycle. A monitor compares it there against the expected word that the read task pushed into the scoreboard queue. Register, pending, stack and status changes from a write or from a vector read take effect at the edge that ends that bus cycle, so the next read already sees them. irq_o lags by one further edge. The bench checks irq_o one clock after each stimulus, and once checks explicitly that it has not yet moved right after the accepting edge. A latched-type input pulse is captured at the edge where it is high, and its effect on irq_o appears one edge after that.

// File: rtl/selvic_pkg.sv
// Shared constants of the indirect-select vectored interrupt controller:
// register byte offsets and field widths. Assumes an 8-bit byte address bus.
package selvic_pkg;
    localparam int PRIO_W  = 3;
    localparam int MODE_W  = 5;    // {type[1:0], prio[2:0]} as stored
    localparam int MAX_SRC = 128;

    localparam logic [7:0] OFS_SEL  = 8'h00;
    localparam logic [7:0] OFS_MODE = 8'h04;
    localparam logic [7:0] OFS_VEC  = 8'h08;
    localparam logic [7:0] OFS_IVR  = 8'h10;
    localparam logic [7:0] OFS_STAT = 8'h18;
    localparam logic [7:0] OFS_PND0 = 8'h20;
    localparam logic [7:0] OFS_PND1 = 8'h24;
    localparam logic [7:0] OFS_PND2 = 8'h28;
    localparam logic [7:0] OFS_PND3 = 8'h2C;
    localparam logic [7:0] OFS_MASK = 8'h30;
    localparam logic [7:0] OFS_CORE = 8'h34;
    localparam logic [7:0] OFS_EOI  = 8'h38;
    localparam logic [7:0] OFS_SPUR = 8'h3C;
    localparam logic [7:0] OFS_EN   = 8'h40;
    localparam logic [7:0] OFS_DIS  = 8'h44;
    localparam logic [7:0] OFS_CLR  = 8'h48;
    localparam logic [7:0] OFS_SET  = 8'h4C;
endpackage

// File: rtl/selvic_srcbank.sv
// Per-source state: mode, vector, enable and pending flag for every source.
// Commands act on the source named by sel_i. Mode bit 3 (type bit 0) marks a
// latched source. Assumes at most one command per cycle.
module selvic_srcbank
    import selvic_pkg::*;
#(
    parameter int NSRC  = 128,
    parameter int VEC_W = 32,
    parameter int IDX_W = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSRC-1:0]              src_i,
    input  logic [IDX_W-1:0]             sel_i,
    input  logic                         mode_we_i,
    input  logic [MODE_W-1:0]            mode_wd_i,
    input  logic                         vec_we_i,
    input  logic [VEC_W-1:0]             vec_wd_i,
    input  logic                         en_i,
    input  logic                         dis_i,
    input  logic                         set_i,
    input  logic                         clr_i,
    input  logic                         ack_i,
    input  logic [IDX_W-1:0]             ack_idx_i,
    input  logic [IDX_W-1:0]             look_idx_i,
    output logic [NSRC-1:0][PRIO_W-1:0]  prio_o,
    output logic [NSRC-1:0]              elig_o,
    output logic [NSRC-1:0]              pend_o,
    output logic [MODE_W-1:0]            sel_mode_o,
    output logic [VEC_W-1:0]             sel_vec_o,
    output logic                         sel_en_o,
    output logic [VEC_W-1:0]             look_vec_o
);
    logic [MODE_W-1:0] mode_a [NSRC];
    logic [VEC_W-1:0]  vec_a  [NSRC];
    logic [NSRC-1:0]   en_v;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic              hit, acked, latched, en_r, pq_r;
        logic [MODE_W-1:0] mode_r;
        logic [VEC_W-1:0]  vec_r;

        assign hit     = (sel_i == IDX_W'(g));
        assign acked   = ack_i && (ack_idx_i == IDX_W'(g));
        assign latched = mode_r[3];

        // Configuration registers of this source.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_r <= '0;
                vec_r  <= '0;
            end else begin
                if (mode_we_i && hit) mode_r <= mode_wd_i;
                if (vec_we_i && hit)  vec_r  <= vec_wd_i;
            end
        end

        // Enable flag: set and clear commands.
        always_ff @(posedge clk) begin
            if (!rst_n) en_r <= 1'b0;
            else        en_r <= (en_r | (en_i & hit)) & ~(dis_i & hit);
        end

        // Remembered pending flag: a new input pulse or set wins over clear/ack.
        always_ff @(posedge clk) begin
            if (!rst_n) pq_r <= 1'b0;
            else        pq_r <= (pq_r & ~(clr_i & hit) & ~acked)
                              | (set_i & hit) | (latched & src_i[g]);
        end

        assign mode_a[g] = mode_r;
        assign vec_a[g]  = vec_r;
        assign en_v[g]   = en_r;
        assign pend_o[g] = pq_r | (~latched & src_i[g]);
        assign elig_o[g] = pend_o[g] & en_r;
        assign prio_o[g] = mode_r[PRIO_W-1:0];
    end

    assign sel_mode_o = mode_a[sel_i];
    assign sel_vec_o  = vec_a[sel_i];
    assign sel_en_o   = en_v[sel_i];
    assign look_vec_o = vec_a[look_idx_i];
endmodule

// File: rtl/selvic_arbiter.sv
// Picks the eligible source with the highest priority; the strict compare
// keeps the lowest index on a tie. Purely combinational.
module selvic_arbiter
    import selvic_pkg::*;
#(
    parameter int NSRC  = 128,
    parameter int IDX_W = 7
) (
    input  logic [NSRC-1:0]             elig_i,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
    output logic                        any_o,
    output logic [IDX_W-1:0]            idx_o,
    output logic [PRIO_W-1:0]           prio_o
);
    // Linear scan from index 0 upward.
    always_comb begin
        any_o  = 1'b0;
        idx_o  = '0;
        prio_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig_i[i] && (!any_o || prio_i[i] > prio_o)) begin
                any_o  = 1'b1;
                idx_o  = IDX_W'(i);
                prio_o = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/selvic_nest.sv
// Nesting stack of acknowledged interrupts (priority and source index).
// Push on full and pop on empty are ignored. Assumes push and pop never coincide.
module selvic_nest
    import selvic_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = 7,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic [PRIO_W-1:0]  push_prio_i,
    input  logic [IDX_W-1:0]   push_idx_i,
    input  logic               pop_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [PRIO_W-1:0]  top_prio_o,
    output logic [IDX_W-1:0]   top_idx_o
);
    logic [PRIO_W-1:0] prio_s [DEPTH];
    logic [IDX_W-1:0]  idx_s  [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic [PTR_W-1:0]  top_ptr;

    assign top_ptr = PTR_W'(cnt_q - 1'b1);

    // Stack storage and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                prio_s[i] <= '0;
                idx_s[i]  <= '0;
            end
        end else if (push_i && cnt_q < CNT_W'(DEPTH)) begin
            prio_s[PTR_W'(cnt_q)] <= push_prio_i;
            idx_s[PTR_W'(cnt_q)]  <= push_idx_i;
            cnt_q <= cnt_q + 1'b1;
        end else if (pop_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o      = cnt_q;
    assign top_prio_o = prio_s[top_ptr];
    assign top_idx_o  = idx_s[top_ptr];
endmodule

// File: rtl/selvic.sv
// Top of the indirect-select vectored interrupt controller. Decodes the
// register bus, holds the select and spurious registers, and registers the
// interrupt output. Assumes one bus access (read or write) per cycle.
module selvic
    import selvic_pkg::*;
#(
    parameter int NSRC  = 128,
    parameter int VEC_W = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_i,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             irq_o
);
    localparam int IDX_W = $clog2(NSRC);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [IDX_W-1:0]             sel_q;
    logic [31:0]                  spur_q;
    logic                         irq_q;
    logic                         sel_ok;
    logic                         mode_we, vec_we, en_cmd, dis_cmd, set_cmd, clr_cmd;
    logic                         ivr_rd, take, eoi_wr, cand, stk_empty;
    logic [NSRC-1:0][PRIO_W-1:0]  prio_a;
    logic [NSRC-1:0]              elig, pend;
    logic [MODE_W-1:0]            sel_mode;
    logic [VEC_W-1:0]             sel_vec, win_vec;
    logic                         sel_en, win_any;
    logic [IDX_W-1:0]             win_idx, top_idx;
    logic [PRIO_W-1:0]            win_prio, top_prio;
    logic [CNT_W-1:0]             stk_cnt;
    logic [MAX_SRC-1:0]           pend_pad;

    assign sel_ok  = {1'b0, sel_q} < (IDX_W + 1)'(NSRC);
    assign mode_we = bus_wr && bus_addr == OFS_MODE && sel_ok;
    assign vec_we  = bus_wr && bus_addr == OFS_VEC && sel_ok;
    assign en_cmd  = bus_wr && bus_addr == OFS_EN && bus_wdata[0] && sel_ok;
    assign dis_cmd = bus_wr && bus_addr == OFS_DIS && bus_wdata[0] && sel_ok;
    assign set_cmd = bus_wr && bus_addr == OFS_SET && bus_wdata[0] && sel_ok;
    assign clr_cmd = bus_wr && bus_addr == OFS_CLR && bus_wdata[0] && sel_ok;
    assign eoi_wr  = bus_wr && bus_addr == OFS_EOI;
    assign ivr_rd  = bus_rd && bus_addr == OFS_IVR;

    selvic_srcbank #(.NSRC(NSRC), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .sel_i(sel_q),
        .mode_we_i(mode_we), .mode_wd_i({bus_wdata[6:5], bus_wdata[2:0]}),
        .vec_we_i(vec_we), .vec_wd_i(bus_wdata[VEC_W-1:0]),
        .en_i(en_cmd), .dis_i(dis_cmd), .set_i(set_cmd), .clr_i(clr_cmd),
        .ack_i(take), .ack_idx_i(win_idx), .look_idx_i(win_idx),
        .prio_o(prio_a), .elig_o(elig), .pend_o(pend),
        .sel_mode_o(sel_mode), .sel_vec_o(sel_vec), .sel_en_o(sel_en),
        .look_vec_o(win_vec)
    );

    selvic_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
        .elig_i(elig), .prio_i(prio_a),
        .any_o(win_any), .idx_o(win_idx), .prio_o(win_prio)
    );

    selvic_nest #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_nest (
        .clk(clk), .rst_n(rst_n),
        .push_i(take), .push_prio_i(win_prio), .push_idx_i(win_idx),
        .pop_i(eoi_wr),
        .cnt_o(stk_cnt), .top_prio_o(top_prio), .top_idx_o(top_idx)
    );

    assign stk_empty = (stk_cnt == '0);
    assign cand      = win_any && (stk_empty || win_prio > top_prio);
    assign take      = ivr_rd && cand;
    assign pend_pad  = MAX_SRC'(pend);

    // Select register, spurious value and registered interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            spur_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == OFS_SEL)  sel_q  <= bus_wdata[IDX_W-1:0];
            if (bus_wr && bus_addr == OFS_SPUR) spur_q <= bus_wdata;
            irq_q <= cand;
        end
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_SEL:  bus_rdata = 32'(sel_q);
            OFS_MODE: if (sel_ok) bus_rdata = {25'd0, sel_mode[4:3], 2'b00, sel_mode[2:0]};
            OFS_VEC:  if (sel_ok) bus_rdata = 32'(sel_vec);
            OFS_IVR:  bus_rdata = cand ? 32'(win_vec) : spur_q;
            OFS_STAT: bus_rdata = stk_empty ? 32'd0 : 32'(top_idx);
            OFS_PND0, OFS_PND1, OFS_PND2, OFS_PND3:
                      bus_rdata = pend_pad[{bus_addr[3:2], 5'd0} +: 32];
            OFS_MASK: bus_rdata = 32'(sel_en && sel_ok);
            OFS_CORE: bus_rdata = 32'(irq_q);
            OFS_SPUR: bus_rdata = spur_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/selvic_chk.sv
// Assertion checker for selvic, attached with bind. Observes the bus, the
// nesting stack occupancy and the arbitration result.
module selvic_chk
    import selvic_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [7:0]       bus_addr,
    input logic [31:0]      bus_rdata,
    input logic             irq_o,
    input logic             cand,
    input logic             any_elig,
    input logic [CNT_W-1:0] stk_cnt,
    input logic [31:0]      spur_q
);
    logic ivr_rd, eoi_wr;
    assign ivr_rd = bus_rd && !bus_wr && bus_addr == OFS_IVR;
    assign eoi_wr = bus_wr && !bus_rd && bus_addr == OFS_EOI;

    // R6: an answered vector read pushes exactly one level
    a_r6_push: assert property (@(posedge clk) disable iff (!rst_n)
        (ivr_rd && cand) |=> stk_cnt == CNT_W'($past(stk_cnt) + 1'b1));

    // R8: end-of-interrupt pops one level when the stack holds something
    a_r8_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && stk_cnt != '0) |=> stk_cnt == CNT_W'($past(stk_cnt) - 1'b1));

    // R8: end-of-interrupt on an empty stack leaves it empty
    a_r8_empty_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && stk_cnt == '0) |=> stk_cnt == '0);

    // R9: a vector read without a winner returns the spurious value
    a_r9_spur_data: assert property (@(posedge clk) disable iff (!rst_n)
        (ivr_rd && !cand) |-> bus_rdata == spur_q);

    // R9: a vector read without a winner does not touch the stack
    a_r9_spur_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ivr_rd && !cand) |=> $stable(stk_cnt));

    // R7: the stack never holds more than its depth
    a_r7_depth: assert property (@(posedge clk) disable iff (!rst_n)
        stk_cnt <= CNT_W'(DEPTH));

    // R10: a raised interrupt implies an eligible source one edge earlier
    a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(any_elig));
endmodule

bind selvic selvic_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .cand(cand), .any_elig(win_any), .stk_cnt(stk_cnt), .spur_q(spur_q)
);

// File: tb/sim_selvic.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks push expected words, a falling-edge monitor
// pops and compares them against bus_rdata.
module sim_selvic;
    localparam int NSRC = 128;
    localparam logic [7:0] A_SEL = 8'h00, A_MODE = 8'h04, A_VEC = 8'h08,
        A_IVR = 8'h10, A_STAT = 8'h18, A_PND0 = 8'h20, A_PND2 = 8'h28,
        A_MASK = 8'h30, A_CORE = 8'h34, A_EOI = 8'h38, A_SPUR = 8'h3C,
        A_EN = 8'h40, A_DIS = 8'h44, A_CLR = 8'h48, A_SET = 8'h4C;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_i = '0;
    logic            bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct { logic [31:0] exp; string tag; } item_t;
    item_t sbq[$];

    always #2.5 clk = ~clk;

    selvic #(.NSRC(NSRC)) u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // Monitor: compare read data in the middle of each read cycle.
    always @(negedge clk) begin
        if (bus_rd) begin
            item_t it;
            checks++;
            if (sbq.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: got %h", bus_rdata);
            end else begin
                it = sbq.pop_front();
                if (bus_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        @(posedge clk); #1;
        sbq.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        checks++;
        if (irq_o !== e) begin
            errors++;
            $display("FAIL %s: irq_o got %b expected %b", tag, irq_o, e);
        end
    endtask

    task automatic settle;
        @(posedge clk); #1;
    endtask

    task automatic cfg(input int idx, input logic [31:0] mode, input logic [31:0] vec);
        wr(A_SEL, idx);
        wr(A_MODE, mode);
        wr(A_VEC, vec);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk_irq(1'b0, "R1 irq after reset");
        rd(A_MODE, 32'h0, "R1 mode reset");
        rd(A_VEC,  32'h0, "R1 vector reset");
        rd(A_SPUR, 32'h0, "R1 spurious reset");
        rd(A_STAT, 32'h0, "R1 status reset");
        rd(A_PND0, 32'h0, "R1 pending reset");
        rd(A_IVR,  32'h0, "R1 vector read returns spurious 0");

        // R9: spurious value
        wr(A_SPUR, 32'hDEAD_BEEF);
        rd(A_SPUR, 32'hDEAD_BEEF, "R9 spurious readback");
        rd(A_IVR,  32'hDEAD_BEEF, "R9 idle vector read");
        rd(A_STAT, 32'h0, "R9 idle read leaves stack empty");

        // R2: per-source configuration through the select register
        cfg(5, 32'h23, 32'h500);   // prio 3, latched
        cfg(9, 32'h03, 32'h900);   // prio 3, level
        wr(A_SEL, 5);
        rd(A_SEL,  32'd5,   "R2 select readback");
        rd(A_MODE, 32'h23,  "R2 mode of source 5");
        rd(A_VEC,  32'h500, "R2 vector of source 5");
        wr(A_SEL, 9);
        rd(A_MODE, 32'h03,  "R2 mode of source 9");
        rd(A_VEC,  32'h900, "R2 vector of source 9");

        // R3: enable command with bit 0 clear is ignored
        wr(A_EN, 32'h0);
        rd(A_MASK, 32'h0, "R3 enable with bit0=0 ignored");
        wr(A_EN, 32'h1);
        rd(A_MASK, 32'h1, "R3 enable sets mask");

        // R12/R4: level source follows its input
        src_i[9] = 1'b1;
        rd(A_PND0, 32'h200, "R12 level pending");
        settle();
        chk_irq(1'b1, "R10 level source raises irq");
        src_i[9] = 1'b0;
        rd(A_PND0, 32'h0, "R12 level pending drops");
        settle();
        chk_irq(1'b0, "R10 irq drops with input");

        // R4/R3: set on a disabled source, then enable timing (R10)
        wr(A_SEL, 5);
        wr(A_SET, 32'h1);
        rd(A_PND0, 32'h20, "R4 set command pends source 5");
        settle();
        chk_irq(1'b0, "R3 disabled source gives no irq");
        wr(A_EN, 32'h1);
        chk_irq(1'b0, "R10 irq not yet at accepting edge");
        settle();
        chk_irq(1'b1, "R10 irq one edge after enable");
        wr(A_CLR, 32'h1);
        rd(A_PND0, 32'h0, "R4 clear command");
        settle();
        chk_irq(1'b0, "R4 irq low after clear");
        wr(A_SET, 32'h1);

        // R5: equal priority, lowest index wins; R6 acknowledge
        src_i[9] = 1'b1;
        rd(A_PND0, 32'h220, "R4 two sources pending");
        settle();
        chk_irq(1'b1, "R7 irq with empty stack");
        rd(A_IVR,  32'h500, "R5 tie goes to lower index");
        rd(A_STAT, 32'd5,   "R6 status shows acknowledged source");
        rd(A_PND0, 32'h200, "R6 ack clears latched pending, R12 level stays");
        settle();
        chk_irq(1'b0, "R7 equal priority does not nest");
        rd(A_IVR,  32'hDEAD_BEEF, "R9 no winner returns spurious");
        rd(A_STAT, 32'd5, "R9 spurious read keeps stack");

        // R7: higher priority nests; source 70 sits in word 2 bit 6
        cfg(70, 32'h26, 32'h7070);
        wr(A_EN, 32'h1);
        @(posedge clk); #1 src_i[70] = 1'b1;
        @(posedge clk); #1 src_i[70] = 1'b0;
        rd(A_PND2, 32'h40, "R4 latched pulse held in word 2");
        settle();
        chk_irq(1'b1, "R7 higher priority interrupts");
        rd(A_IVR,  32'h7070, "R5 higher priority vector");
        rd(A_STAT, 32'd70,   "R6 nested status");

        // R8: unwinding
        wr(A_EOI, 32'h0);
        rd(A_STAT, 32'd5, "R8 pop back to source 5");
        settle();
        chk_irq(1'b0, "R7 level source blocked by equal top");
        wr(A_EOI, 32'h0);
        rd(A_STAT, 32'd0, "R8 stack empty");
        settle();
        chk_irq(1'b1, "R7 level source interrupts after unwind");
        rd(A_IVR,  32'h900, "R5 level source vector");
        rd(A_PND0, 32'h200, "R12 ack leaves level source pending");

        // R5: priority beats index
        cfg(2, 32'h21, 32'h222);
        wr(A_EN, 32'h1);
        wr(A_SET, 32'h1);
        settle();
        chk_irq(1'b0, "R7 lower priority blocked");
        wr(A_EOI, 32'h0);
        rd(A_IVR, 32'h900, "R5 higher priority beats lower index");
        wr(A_EOI, 32'h0);
        src_i[9] = 1'b0;
        rd(A_IVR,  32'h222, "R5 remaining source");
        rd(A_STAT, 32'd2, "R6 status source 2");
        wr(A_EOI, 32'h0);

        // R8: fill all eight levels then unwind with eight writes
        for (int k = 0; k < 8; k++) begin
            cfg(20 + k, 32'h20 | k, 32'h1014 + k);
            wr(A_EN, 32'h1);
        end
        for (int k = 0; k < 8; k++) begin
            wr(A_SEL, 20 + k);
            wr(A_SET, 32'h1);
            rd(A_IVR, 32'h1014 + k, "R8 build nested level");
        end
        rd(A_STAT, 32'd27, "R8 deepest level on top");
        for (int k = 0; k < 7; k++) wr(A_EOI, 32'h0);
        rd(A_STAT, 32'd20, "R8 one level left");
        wr(A_EOI, 32'h0);
        rd(A_STAT, 32'd0, "R8 eight writes empty the stack");
        wr(A_EOI, 32'h0);
        rd(A_STAT, 32'd0, "R8 extra write on empty stack ignored");
        wr(A_SEL, 25);
        wr(A_SET, 32'h1);
        settle();
        chk_irq(1'b1, "R8 no lockout after unwind");

        // R3: disable removes the request; R11 core status
        wr(A_DIS, 32'h1);
        rd(A_MASK, 32'h0, "R3 disable clears mask");
        settle();
        chk_irq(1'b0, "R3 disabled source drops irq");
        rd(A_CORE, 32'h0, "R11 core status low");
        wr(A_EN, 32'h1);
        settle();
        chk_irq(1'b1, "R3 re-enable restores irq");
        rd(A_CORE, 32'h1, "R11 core status high");
        rd(A_IVR,  32'h1019, "R5 vector of source 25");
        rd(A_STAT, 32'd25, "R6 status source 25");
        settle();
        chk_irq(1'b0, "R6 acknowledged source no longer requests");
        wr(A_EOI, 32'h0);

        settle();
        done = 1;
        summary();
        $finish;
    end
endmodule